// File: doc/BRIEF.md
# Boost Frequency Governor Engine

This block holds the boost term of one activity-monitor channel and works out what to do with it each time that channel raises an interrupt. A one-cycle `start` pulse latches the sampled average activity count, the two consecutive-breach cause bits, the ceiling frequency and the channel's tuning values. The engine then runs one fixed sequence of integer divisions on a single shared restoring divider. Each division produces one quotient bit per clock.

From that sequence it produces four results. The first is a new boost value: it grows geometrically plus a fixed step toward the ceiling, and it decays geometrically toward zero. The second is a pair of average watermarks centred on the sampled count. The third is the updated enables for the two consecutive-breach interrupts, which switch off a direction once it has saturated. The fourth is a target frequency in kHz. All values are in kHz or in raw counts. A one-cycle `done` pulse, together with a one-cycle status-clear strobe, marks that the results are valid. Changing the clock is left to the logic downstream.

Top module: `boost_gov`

## Requirements
- R1: After reset, `boost` and `target` are 0, `en_above` and `en_below` are 1, and `busy`, `done` and `clr_status` are 0.
- R2: When `ev_up`=1, the new boost is floor(boost*up_gain/100)+16000. If that value is at or above `fmax`, boost becomes `fmax` and `en_above` is cleared. Otherwise `en_above` is set. `en_below` is set in both cases.
- R3: When `ev_dn`=1 and `ev_up`=0, the new boost is floor(boost*dn_gain/100). If that value is below 8000, boost becomes 0 and `en_below` is cleared. Otherwise `en_below` is set. `en_above` is set in both cases.
- R4: When both cause bits are 1, only the R2 rule is applied.
- R5: When both cause bits are 0, boost and `en_above` keep their values. `en_below` also keeps its value unless R8 changes it.
- R6: Let band = floor(fmax*6/1000)*12. Then `wm_avg_hi` = avg + band and `wm_avg_lo` = max(avg, band) − band, with all operands within 32 bits.
- R7: `target` = floor(floor(floor(avg/12) * floor(10000/up_thr)) / 100) + new boost. `up_thr` must be nonzero.
- R8: When `dep_thr` is nonzero, the final step sets `en_below` if avg ≥ `dep_thr`. If avg < `dep_thr` and the new boost is 0, it clears `en_below` instead. When `dep_thr` is 0, this rule does nothing.
- R9: `done` and `clr_status` are high together for exactly one cycle per accepted start. `busy` is high from the cycle after an accepted start until `done` rises.
- R10: A `start` pulse that arrives while `busy` is 1 is ignored. The result in progress still uses the inputs latched at the accepted start, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches one update |
| ev_up | input | 1 | Cause: consecutive samples above the upper watermark |
| ev_dn | input | 1 | Cause: consecutive samples below the lower watermark |
| avg_in | input | W | Sampled average activity count |
| fmax | input | W | Ceiling frequency in kHz |
| dep_thr | input | W | Activity level that keeps the below-enable on; 0 disables the rule |
| up_gain | input | CW | Growth factor in percent |
| dn_gain | input | CW | Decay factor in percent |
| up_thr | input | TW | Upper threshold in percent, used to scale the target |
| boost | output | W | Current boost in kHz |
| target | output | W | Target frequency in kHz |
| wm_avg_hi | output | W | New upper average watermark |
| wm_avg_lo | output | W | New lower average watermark |
| en_above | output | 1 | Enable for the consecutive-above interrupt |
| en_below | output | 1 | Enable for the consecutive-below interrupt |
| clr_status | output | 1 | One-cycle strobe that clears all status bits |
| busy | output | 1 | An update is in progress |
| done | output | 1 | One-cycle pulse: the results are valid |

## Verification
The bench drives the boost up repeatedly against a low ceiling. A design that compares with `>` instead of `>=`, or that leaves `en_above` set, would let a saturated boost keep firing. It drives the boost down until the product falls under half a step, to catch a design that stalls at a small nonzero value or leaves `en_below` on. It sets both cause bits at once, and it sets neither bit with the dependency threshold on both sides of the average, to expose a wrong priority or a dependency rule that reads the old boost. A start pulse issued in the middle of a computation would, in a faulty design, relatch inputs or produce a second `done`. The bench also uses averages smaller than the band, where a plain subtraction would wrap.

// File: rtl/boost_gov.sv
module boost_gov #(
  parameter int W        = 32,
  parameter int CW       = 16,
  parameter int TW       = 8,
  parameter int DVW      = 16,
  parameter int STEP     = 16000,
  parameter int PCT      = 100,
  parameter int BAND_NUM = 6,
  parameter int BAND_DEN = 1000,
  parameter int PERIOD   = 12,
  parameter int SUSTAIN  = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ev_up,
  input  logic          ev_dn,
  input  logic [W-1:0]  avg_in,
  input  logic [W-1:0]  fmax,
  input  logic [W-1:0]  dep_thr,
  input  logic [CW-1:0] up_gain,
  input  logic [CW-1:0] dn_gain,
  input  logic [TW-1:0] up_thr,
  output logic [W-1:0]  boost,
  output logic [W-1:0]  target,
  output logic [W-1:0]  wm_avg_hi,
  output logic [W-1:0]  wm_avg_lo,
  output logic          en_above,
  output logic          en_below,
  output logic          clr_status,
  output logic          busy,
  output logic          done
);
  localparam int DW   = W + CW;
  localparam int CNTW = $clog2(DW + 1);
  localparam int HALF = STEP / 2;
  localparam int LAST = 4;

  typedef enum logic [2:0] {IDLE, LOAD, DIV, STORE, FIN} st_t;
  st_t st;

  logic [W-1:0]    a_avg, a_max, a_dep;
  logic            a_up, a_dn;
  logic [CW-1:0]   a_upg, a_dng;
  logic [TW-1:0]   a_thr;
  logic [W-1:0]    band_q, t1, prod_q;
  logic [CW-1:0]   sus;
  logic [2:0]      op;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   quo;
  logic [DVW:0]    rem;
  logic [DVW-1:0]  dvs;

  logic [DW-1:0]   dvd_sel;
  logic [DVW-1:0]  dvs_sel;

  always_comb begin
    case (op)
      3'd0:    begin dvd_sel = DW'(a_max) * DW'(BAND_NUM);            dvs_sel = DVW'(BAND_DEN); end
      3'd1:    begin dvd_sel = DW'(boost) * DW'(a_up ? a_upg : a_dng); dvs_sel = DVW'(PCT);      end
      3'd2:    begin dvd_sel = DW'(a_avg);                            dvs_sel = DVW'(PERIOD);   end
      3'd3:    begin dvd_sel = DW'(SUSTAIN);                          dvs_sel = DVW'(a_thr);    end
      default: begin dvd_sel = DW'(t1) * DW'(sus);                    dvs_sel = DVW'(PCT);      end
    endcase
  end

  wire [DVW:0]   rem_sh  = {rem[DVW-1:0], quo[DW-1]};
  wire           fits    = rem_sh >= {1'b0, dvs};
  wire [DW:0]    up_sum  = {1'b0, quo} + (DW+1)'(STEP);
  wire           up_sat  = up_sum >= (DW+1)'(a_max);
  wire           dn_zero = quo < DW'(HALF);
  wire [W-1:0]   band_w  = W'(band_q * W'(PERIOD));
  wire [W-1:0]   lo_base = (a_avg > band_w) ? a_avg : band_w;

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      op <= '0;
      cnt <= '0;
      quo <= '0;
      rem <= '0;
      dvs <= '0;
      a_avg <= '0; a_max <= '0; a_dep <= '0;
      a_up <= 1'b0; a_dn <= 1'b0;
      a_upg <= '0; a_dng <= '0; a_thr <= '0;
      band_q <= '0; t1 <= '0; prod_q <= '0; sus <= '0;
      boost <= '0;
      target <= '0;
      wm_avg_hi <= '0;
      wm_avg_lo <= '0;
      en_above <= 1'b1;
      en_below <= 1'b1;
      clr_status <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      clr_status <= 1'b0;
      case (st)
        IDLE: if (start) begin
          a_avg <= avg_in; a_max <= fmax; a_dep <= dep_thr;
          a_up <= ev_up; a_dn <= ev_dn;
          a_upg <= up_gain; a_dng <= dn_gain; a_thr <= up_thr;
          op <= '0;
          st <= LOAD;
        end
        LOAD: begin
          quo <= dvd_sel;
          dvs <= dvs_sel;
          rem <= '0;
          cnt <= '0;
          st <= DIV;
        end
        DIV: begin
          rem <= fits ? (rem_sh - {1'b0, dvs}) : rem_sh;
          quo <= {quo[DW-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CNTW'(DW - 1)) st <= STORE;
        end
        STORE: begin
          case (op)
            3'd0: band_q <= quo[W-1:0];
            3'd1: begin
              if (a_up) begin
                en_below <= 1'b1;
                if (up_sat) begin
                  boost <= a_max;
                  en_above <= 1'b0;
                end else begin
                  boost <= up_sum[W-1:0];
                  en_above <= 1'b1;
                end
              end else if (a_dn) begin
                en_above <= 1'b1;
                if (dn_zero) begin
                  boost <= '0;
                  en_below <= 1'b0;
                end else begin
                  boost <= quo[W-1:0];
                  en_below <= 1'b1;
                end
              end
            end
            3'd2: t1 <= quo[W-1:0];
            3'd3: sus <= quo[CW-1:0];
            default: prod_q <= quo[W-1:0];
          endcase
          if (op == 3'(LAST)) st <= FIN;
          else begin
            op <= op + 1'b1;
            st <= LOAD;
          end
        end
        FIN: begin
          target <= prod_q + boost;
          wm_avg_hi <= a_avg + band_w;
          wm_avg_lo <= lo_base - band_w;
          if (a_dep != '0) begin
            if (a_avg >= a_dep) en_below <= 1'b1;
            else if (boost == '0) en_below <= 1'b0;
          end
          done <= 1'b1;
          clr_status <= 1'b1;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module boost_gov_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         clr_status,
  input logic [W-1:0] boost,
  input logic [W-1:0] target,
  input logic [W-1:0] wm_avg_hi,
  input logic [W-1:0] wm_avg_lo
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && clr_status));
  p_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_run_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
  p_idle_boost_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(boost));
  p_idle_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(target));
  p_wm_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wm_avg_lo <= wm_avg_hi));
endmodule

bind boost_gov boost_gov_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .clr_status(clr_status), .boost(boost), .target(target),
  .wm_avg_hi(wm_avg_hi), .wm_avg_lo(wm_avg_lo)
);

// File: tb/boost_gov_bench.sv
`timescale 1ns/1ps
module boost_gov_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ev_up = 1'b0, ev_dn = 1'b0;
  logic [31:0] avg_in = '0, fmax = '0, dep_thr = '0;
  logic [15:0] up_gain = '0, dn_gain = '0;
  logic [7:0]  up_thr = 8'd1;
  logic [31:0] boost, target, wm_avg_hi, wm_avg_lo;
  logic en_above, en_below, clr_status, busy, done;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  longint m_boost = 0;
  bit m_above = 1'b1, m_below = 1'b1;

  always #2.5 clk = ~clk;

  boost_gov u_boost_gov (
    .clk(clk), .rst_n(rst_n), .start(start), .ev_up(ev_up), .ev_dn(ev_dn),
    .avg_in(avg_in), .fmax(fmax), .dep_thr(dep_thr), .up_gain(up_gain),
    .dn_gain(dn_gain), .up_thr(up_thr), .boost(boost), .target(target),
    .wm_avg_hi(wm_avg_hi), .wm_avg_lo(wm_avg_lo), .en_above(en_above),
    .en_below(en_below), .clr_status(clr_status), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint f_band(input longint mx);
    return (mx * 6 / 1000) * 12;
  endfunction

  function automatic longint f_target(input longint avg, input longint thr, input longint b);
    return ((avg / 12) * (10000 / thr)) / 100 + b;
  endfunction

  task automatic run_op(input bit up, input bit dn, input longint avg, input longint mx,
                        input longint dep, input longint ug, input longint dg,
                        input longint thr, input bit poke);
    longint q, band, lo_b;
    int dones;
    @(negedge clk);
    ev_up = up; ev_dn = dn; avg_in = 32'(avg); fmax = 32'(mx); dep_thr = 32'(dep);
    up_gain = 16'(ug); dn_gain = 16'(dg); up_thr = 8'(thr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      ev_up = ~up; ev_dn = ~dn; avg_in = 32'd123456; fmax = 32'd50000;
      up_gain = 16'd333; dn_gain = 16'd11; up_thr = 8'd7; dep_thr = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 still busy after ignored start", busy, 1);
    end
    if (up) begin
      q = m_boost * ug / 100 + 16000;
      if (q >= mx) begin m_boost = mx; m_above = 1'b0; end
      else begin m_boost = q; m_above = 1'b1; end
      m_below = 1'b1;
    end else if (dn) begin
      q = m_boost * dg / 100;
      if (q < 8000) begin m_boost = 0; m_below = 1'b0; end
      else begin m_boost = q; m_below = 1'b1; end
      m_above = 1'b1;
    end
    if (dep != 0) begin
      if (avg >= dep) m_below = 1'b1;
      else if (m_boost == 0) m_below = 1'b0;
    end
    band = f_band(mx);
    lo_b = (avg > band) ? avg : band;
    while (!done) @(negedge clk);
    chk("R2/R3/R4/R5 boost", boost, m_boost);
    chk("R2/R3 en_above", en_above, m_above);
    chk("R3/R8 en_below", en_below, m_below);
    chk("R7 target", target, f_target(avg, thr, m_boost));
    chk("R6 wm_avg_hi", wm_avg_hi, avg + band);
    chk("R6 wm_avg_lo", wm_avg_lo, lo_b - band);
    chk("R9 clr_status with done", clr_status, 1);
    chk("R9 busy low at done", busy, 0);
    dones = 0;
    repeat (30) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R9 R10 single done pulse", dones, 0);
    chk("R5 boost held while idle", boost, m_boost);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 boost", boost, 0);
    chk("R1 target", target, 0);
    chk("R1 en_above", en_above, 1);
    chk("R1 en_below", en_below, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 clr_status", clr_status, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: growth until the ceiling clamps
    for (int i = 0; i < 4; i++) run_op(1, 0, 600000, 100000, 0, 800, 90, 27, 0);
    chk("R2 saturated boost equals ceiling", boost, 100000);
    chk("R2 en_above cleared on clamp", en_above, 0);
    // R3: decay to zero
    for (int i = 0; i < 6; i++) run_op(0, 1, 400000, 100000, 0, 800, 50, 60, 0);
    chk("R3 boost decays to zero", boost, 0);
    chk("R3 en_below cleared at zero", en_below, 0);
    // R4: both causes -> growth rule
    run_op(1, 1, 50000, 2000000, 0, 200, 50, 60, 0);
    chk("R4 up wins", boost, 16000);
    // R5/R8: no cause, dependency on both sides
    run_op(0, 0, 70000, 2000000, 50000, 200, 50, 40, 0);
    run_op(0, 1, 10000, 2000000, 0, 200, 10, 40, 0);
    run_op(0, 0, 10000, 2000000, 50000, 200, 50, 40, 0);
    chk("R8 below cleared when boost 0 and avg low", en_below, 0);
    // R6: avg below band
    run_op(0, 0, 100, 1000000, 0, 200, 50, 60, 0);
    chk("R6 lower watermark floors at zero", wm_avg_lo, 0);
    // R10: start while busy
    run_op(1, 0, 900000, 1500000, 0, 300, 50, 33, 1);

    for (int i = 0; i < 50; i++) begin
      bit u, d;
      longint mx, av, dp;
      u = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      mx = longint'($urandom_range(16000, 2000000));
      av = longint'($urandom_range(0, 30000000));
      dp = ($urandom_range(0, 2) == 0) ? 0 : longint'($urandom_range(1, 30000000));
      run_op(u, d, av, mx, dp, longint'($urandom_range(100, 1000)),
             longint'($urandom_range(10, 99)), longint'($urandom_range(5, 100)),
             ($urandom_range(0, 7) == 0));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule